// File: doc/BRIEF.md
# Interval Timer Channel with Toggle Output

This block is one 16-bit down-counting timer channel. It produces a periodic interrupt pulse and, when wanted, a square wave on a single output. A small prescaler divides the system clock into a one-cycle count enable. Software picks the divide ratio through a two-bit select.

Software controls the channel through a register-style write port and a combinational read port. It writes a period value, sets the mode and the clock select while the channel is idle, and starts or stops counting with self-clearing trigger bits. It can read the live counter at any time.

After a start, the first count enable copies the period into the counter. Each later enable decrements it. The enable that follows a count of zero reloads the period, raises the interrupt for one cycle and toggles the output. A stop freezes both the counter and the output level. An output-enable bit chooses who drives the output: when it is clear, software sets the level directly; when it is set, only the timer toggles the level.

Top module: `itmr_channel`

## Requirements
- R1: A write to address 2 with bit 0 set starts the channel, and `running` goes to 1 on the next cycle. Bit 1 of the same address is the stop trigger. Reading address 2 returns `running` in bit 2, and the trigger bits always read 0.
- R2: After a start, the counter keeps its old value until the next count enable, which copies the period into the counter.
- R3: Bit 0 of address 3 is the mode bit. When the mode bit is 1, the first load after a start also raises the interrupt and toggles the output. When it is 0, the first load does neither.
- R4: While running, the counter, read at address 1, drops by one on each count enable.
- R5: With the counter at 0, the next count enable reloads the period, holds `irq` high for exactly one cycle and toggles the output. Interrupts therefore come every period+1 count enables.
- R6: A stop write clears `running`. After it, the counter and the output keep their values and no interrupt occurs.
- R7: The period register at address 0 may be rewritten while running. The new value is first used at the next reload.
- R8: Writes to address 3 (bit 0 mode, bits 2:1 clock select) are ignored while running.
- R9: Address 4 holds the output level in bit 0 and the output enable in bit 1. A write while the enable is 0 sets the output to the written level. While the enable is 1, written levels are ignored and only timer toggles change the output.
- R10: Clock-select values 0, 1, 2 and 3 give count enables every 1, 2, 4 and 16 system cycles. The interrupt spacing is therefore ratio × (period+1) cycles.
- R11: Synchronous active-low reset clears the counter, the period, the mode bit, the clock select, `running`, the output, the output enable and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | One-cycle interrupt pulse |
| tout | output | 1 | Timer output level |
| running | output | 1 | Channel running status |

## Verification
Some rules are checked by assertions on every cycle:
- the counter steps down by exactly one per enable,
- a reload takes the period value,
- an idle counter never moves,
- a start always leaves the channel running,
- the output level never moves without a toggle while the enable is set,
- the configuration never changes while running.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle of the first load after a start,
- the difference between the two mode settings,
- a rewritten period taking effect only at the next reload,
- the spacing of interrupts under each divide ratio,
- the read-back of the register fields.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 4;

  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd3;
  localparam logic [ADDR_W-1:0] A_OUT    = 3'd4;

  // log2 of the divide ratio for each clock-select code
  function automatic int unsigned div_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 4;
    endcase
  endfunction

  // low-bit mask that must be all ones on the free-running divider
  function automatic logic [PS_W-1:0] div_mask(input logic [1:0] sel);
    return PS_W'((1 << div_log2(sel)) - 1);
  endfunction

  // counter value after one enable while counting (not a first load)
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] per);
    return (cur == '0) ? per : cur - 1'b1;
  endfunction
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
  import itmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign mask   = div_mask(sel_i);
  assign tick_o = ((div_q & mask) == mask);

  // R10: the fastest ratio gives an enable on every cycle
  p_sel0_every_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'd0) |-> tick_o);
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             fire_o,
  output logic             irq_o
);
  logic             run_q, pend_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             adv, load_evt, reload_evt;

  assign adv        = tick_i && run_q && !stop_i && !start_i;
  assign load_evt   = adv && pend_q;
  assign reload_evt = adv && !pend_q && (cnt_q == '0);
  assign fire_o     = reload_evt || (load_evt && mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire_o;
      if (stop_i) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (start_i) begin
        run_q  <= 1'b1;
        pend_q <= 1'b1;
      end else if (load_evt) begin
        pend_q <= 1'b0;
      end
      if (load_evt)  cnt_q <= period_i;
      else if (adv)  cnt_q <= next_count(cnt_q, period_i);
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
  assign irq_o   = irq_q;

  p_start_sets_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> run_q);
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pend_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_irq_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick_i));
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_q));
  p_reload_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (cnt_q == $past(period_i)));
endmodule

// File: rtl/itmr_outctl.sv
module itmr_outctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic lvl_i,
  input  logic oe_i,
  input  logic toggle_i,
  output logic tout_o,
  output logic oe_o
);
  logic tout_q, oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (wr_i) oe_q <= oe_i;
      if (wr_i && !oe_q)          tout_q <= lvl_i;
      else if (toggle_i && oe_q)  tout_q <= ~tout_q;
    end
  end

  assign tout_o = tout_q;
  assign oe_o   = oe_q;

  p_enabled_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !toggle_i) |=> $stable(tout_q));
  p_toggle_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && toggle_i) |=> (tout_q != $past(tout_q)));
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              tout,
  output logic              running
);
  logic [CNT_W-1:0] period_q, count;
  logic             mode_q;
  logic [1:0]       sel_q;
  logic             tick, start_w, stop_w, out_w, fire, oe;

  assign start_w = wr_en && (wr_addr == A_TRIG) && wr_data[0];
  assign stop_w  = wr_en && (wr_addr == A_TRIG) && wr_data[1];
  assign out_w   = wr_en && (wr_addr == A_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      mode_q   <= 1'b0;
      sel_q    <= 2'd0;
    end else begin
      if (wr_en && wr_addr == A_PERIOD) period_q <= wr_data;
      if (wr_en && wr_addr == A_CFG && !running) begin
        mode_q <= wr_data[0];
        sel_q  <= wr_data[2:1];
      end
    end
  end

  itmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .tick_o(tick)
  );

  itmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start_w), .stop_i(stop_w),
    .mode_i(mode_q), .period_i(period_q), .count_o(count), .run_o(running),
    .fire_o(fire), .irq_o(irq)
  );

  itmr_outctl u_out (
    .clk(clk), .rst_n(rst_n), .wr_i(out_w), .lvl_i(wr_data[0]), .oe_i(wr_data[1]),
    .toggle_i(fire), .tout_o(tout), .oe_o(oe)
  );

  always_comb begin
    case (rd_addr)
      A_PERIOD: rd_data = period_q;
      A_COUNT:  rd_data = count;
      A_TRIG:   rd_data = {{(CNT_W-3){1'b0}}, running, 2'b00};
      A_CFG:    rd_data = {{(CNT_W-3){1'b0}}, sel_q, mode_q};
      A_OUT:    rd_data = {{(CNT_W-2){1'b0}}, oe, tout};
      default:  rd_data = '0;
    endcase
  end

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(mode_q) && $stable(sel_q)));
endmodule

// File: tb/itmr_channel_tb_top.sv
module itmr_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq, tout, running;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  itmr_channel dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .tout(tout), .running(running)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd1, v); chk("R11 counter", v, 16'h0);
    rd(3'd0, v); chk("R11 period", v, 16'h0);
    rd(3'd3, v); chk("R11 config", v, 16'h0);
    rd(3'd4, v); chk("R11 output/enable", v, 16'h0);
    chk("R11 running", {15'b0, running}, 16'h0);
    chk("R11 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    wr(3'd4, 16'h2);
    wr(3'd0, 16'd3);
    wr(3'd2, 16'h1);
    chk("R1 running after start", {15'b0, running}, 16'h1);
    rd(3'd2, v); chk("R1 trigger bits read 0", v, 16'h4);
    rd(3'd1, v); chk("R2 no load before enable", v, 16'h0);
    step(); rd(3'd1, v); chk("R2 first load", v, 16'd3);
    chk("R3 mode0 no irq at start", {15'b0, irq}, 16'h0);
    chk("R3 mode0 no toggle at start", {15'b0, tout}, 16'h0);
    step(); rd(3'd1, v); chk("R4 decrement", v, 16'd2);
    step(); step(); rd(3'd1, v); chk("R4 reach zero", v, 16'd0);
    step(); rd(3'd1, v); chk("R5 reload", v, 16'd3);
    chk("R5 irq on reload", {15'b0, irq}, 16'h1);
    chk("R5 toggle on reload", {15'b0, tout}, 16'h1);
    step(); chk("R5 irq one cycle", {15'b0, irq}, 16'h0);
    step(); step(); step();
    chk("R5 second irq after period+1", {15'b0, irq}, 16'h1);
    chk("R5 second toggle", {15'b0, tout}, 16'h0);
    step(); step();
    wr(3'd2, 16'h2);
    chk("R6 stop clears running", {15'b0, running}, 16'h0);
    begin
      logic [15:0] c0;
      logic        t0;
      rd(3'd1, c0); t0 = tout;
      for (int i = 0; i < 6; i++) begin
        step();
        if (irq) chk("R6 no irq when stopped", 16'h1, 16'h0);
      end
      rd(3'd1, v); chk("R6 counter held", v, c0);
      chk("R6 output held", {15'b0, tout}, {15'b0, t0});
    end
  endtask

  task automatic t_mode1_lock();
    logic [15:0] v;
    logic t0;
    wr(3'd3, 16'h1);
    wr(3'd0, 16'd4);
    t0 = tout;
    wr(3'd2, 16'h1);
    step();
    chk("R3 mode1 irq at start", {15'b0, irq}, 16'h1);
    chk("R3 mode1 toggle at start", {15'b0, tout}, {15'b0, ~t0});
    rd(3'd1, v); chk("R3 loaded period", v, 16'd4);
    wr(3'd3, 16'h6);
    rd(3'd1, v); chk("R8 still counting each cycle", v, 16'd3);
    step(); rd(3'd1, v); chk("R8 select unchanged", v, 16'd2);
    wr(3'd2, 16'h2);
    rd(3'd3, v); chk("R8 config write ignored", v, 16'h1);
    wr(3'd3, 16'h0);
  endtask

  task automatic t_period_change();
    logic [15:0] v;
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h1);
    step();
    wr(3'd0, 16'd2);
    rd(3'd1, v); chk("R7 old period still counting", v, 16'd4);
    for (int i = 0; i < 50; i++) begin
      rd(3'd1, v);
      if (v == 16'd0) break;
      step();
    end
    step();
    rd(3'd1, v); chk("R7 new period at reload", v, 16'd2);
    chk("R7 irq at reload", {15'b0, irq}, 16'h1);
    wr(3'd2, 16'h2);
  endtask

  task automatic t_divide(input logic [1:0] s, input int ratio);
    int n;
    bit seen;
    wr(3'd2, 16'h2);
    wr(3'd3, {13'b0, s, 1'b0});
    wr(3'd0, 16'd2);
    wr(3'd2, 16'h1);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (irq) begin seen = 1; break; end
    end
    n = 0;
    if (seen) begin
      for (int i = 0; i < 200; i++) begin
        step(); n++;
        if (irq) break;
      end
    end
    chk($sformatf("R10 spacing sel=%0d", s), 16'(n), 16'(ratio * 3));
    wr(3'd2, 16'h2);
  endtask

  task automatic t_outctl();
    logic [15:0] v;
    logic t0;
    t0 = tout;
    wr(3'd4, 16'h0);
    chk("R9 level ignored while enabled", {15'b0, tout}, {15'b0, t0});
    wr(3'd4, 16'h1);
    chk("R9 direct level 1", {15'b0, tout}, 16'h1);
    wr(3'd4, 16'h0);
    chk("R9 direct level 0", {15'b0, tout}, 16'h0);
    wr(3'd4, 16'h2);
    wr(3'd4, 16'h3);
    chk("R9 level ignored after enable", {15'b0, tout}, 16'h0);
    rd(3'd4, v); chk("R9 readback", v, 16'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_mode1_lock();
    t_period_change();
    t_divide(2'd0, 1);
    t_divide(2'd1, 2);
    t_divide(2'd2, 4);
    t_divide(2'd3, 16);
    t_outctl();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule